// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address. It walks a two-level page table held in memory, using a single-beat read/write port. A request carries the virtual address, the access kind (load, store or fetch), the effective privilege mode, the supervisor-may-touch-user flag, the make-executable-readable flag and the page number of the root table. The walker reads one or two page table entries, runs an ordered set of checks on the leaf, and returns the physical address and the permissions of the page, or it reports a fault.

On a successful walk the block keeps the accessed flag and, for stores, the dirty flag up to date. When either flag has to change, it writes the updated entry back to the address it read the entry from. Only then does it report completion. It is meant to sit behind a translation cache that calls it on a miss. The block keeps no cache of its own.

Page table entry bit positions used throughout: valid bit 0, read 1, write 2, execute 3, user 4, accessed 6, dirty 7, page number bits 31:10. Access kind encoding: 0 load, 1 store, 2 fetch. Mode encoding: 0 user, 1 supervisor, 3 machine.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `mem_req` are low. `done` is a single-cycle pulse, given once per accepted request.
- R2: The first entry is read at byte address root_ppn*4096 + va[31:22]*4. After a pointer, the second is read at ppn*4096 + va[21:12]*4. While `mem_req` waits for `mem_ack`, `mem_addr` holds steady.
- R3: An entry whose valid bit is 0 ends the walk with a fault.
- R4: A valid entry with read, write and execute all 0 is a pointer to the next table. A pointer found in the second-level table faults.
- R5: Leaf entries with write set and read clear (write-only, or write plus execute) fault.
- R6: A leaf with the user bit set faults when the mode is not user, and either the supervisor-may-touch-user flag is 0 or the access is a fetch.
- R7: A leaf with the user bit clear faults when the mode is not supervisor.
- R8: A leaf in the first-level table (a 4 MiB page) faults when page number bits 19:10 of the entry are not all 0.
- R9: A load needs read, or execute together with the make-executable-readable flag. A store needs write. A fetch needs execute. Otherwise the walk faults.
- R10: On success the entry value to store is the old value with accessed set, plus dirty set for stores. It is written to the leaf address only if it differs from the old value. No write happens on a fault.
- R11: On success `pa` is {ppn[21:10], ppn[9:0] OR va[21:12], va[11:0]} for a first-level leaf and {ppn, va[11:0]} for a second-level leaf.
- R12: On success `perm_r` is read OR (execute AND make-executable-readable), `perm_x` is execute, and `perm_w` is write AND (store OR dirty already set).
- R13: When `done` rises with `fault` high, `pa` and all three permission outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk, accepted while `busy` is low |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_mode | input | 2 | Effective mode: 0 user, 1 supervisor, 3 machine |
| req_sum | input | 1 | Supervisor may access user pages |
| req_mxr | input | 1 | Executable pages readable by loads |
| req_root | input | 22 | Page number of the first-level table |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 34 | Byte address of the page table entry |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_ack | input | 1 | Memory completed the request; read data valid |
| mem_rdata | input | 32 | Entry read from memory |
| done | output | 1 | Walk finished (one-cycle pulse) |
| fault | output | 1 | Walk ended in a translation fault, valid with `done` |
| pa | output | 34 | Translated physical address, valid with `done` |
| perm_r | output | 1 | Page readable |
| perm_w | output | 1 | Page writable |
| perm_x | output | 1 | Page executable |

## Verification
The bench goes after the places where an ordered leaf check is easy to get wrong:
- An execute-only page loaded with and without the make-executable-readable flag. A walker that ignored the flag would fault, or would grant a read it should refuse.
- A user page reached by a supervisor fetch while the supervisor-may-touch-user flag is set. A design that skipped the fetch rule would translate it.
- A 4 MiB leaf with a stray low page-number bit. A walker that skipped the alignment check would produce a wrong address.
- A pointer found in the last table, which would otherwise send the walk to a garbage address.
- Write-back with the accessed flag already set on a load. This must cause no memory write, and redundant or missing write-backs show up as a wrong write count.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int PTE_PPN_LSB = 10;

  localparam int B_V = 0;
  localparam int B_R = 1;
  localparam int B_W = 2;
  localparam int B_X = 3;
  localparam int B_U = 4;
  localparam int B_A = 6;
  localparam int B_D = 7;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [1:0] MODE_U = 2'd0;
  localparam logic [1:0] MODE_S = 2'd1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_READ,
    ST_EVAL,
    ST_WRITE
  } walk_st_e;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int PPN_W = 22,
  parameter int VPN_W = 10,
  parameter int LEVELS = 2,
  parameter int OFF_W = 12,
  localparam int VA_W = OFF_W + VPN_W * LEVELS,
  localparam int PA_W = OFF_W + PPN_W,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int ENT_LOG = OFF_W - VPN_W
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [PPN_W-1:0] base_ppn,
  input  logic [LVL_W-1:0] level,
  input  logic [PPN_W-1:0] leaf_ppn,
  output logic [PA_W-1:0]  pte_addr,
  output logic [PA_W-1:0]  phys,
  output logic [PPN_W-1:0] sp_mask
);

  logic [VPN_W-1:0] slice [LEVELS];
  logic [VPN_W-1:0] idx;
  logic [PPN_W-1:0] vpn_ext;

  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign slice[g] = vaddr[OFF_W + g * VPN_W +: VPN_W];
  end

  assign idx = slice[level];

  // index into the current table: base page plus entry offset
  assign pte_addr = {base_ppn, {OFF_W{1'b0}}} | PA_W'({idx, {ENT_LOG{1'b0}}});

  // page number bits covered by a large page at this level
  always_comb begin
    for (int b = 0; b < PPN_W; b++) begin
      sp_mask[b] = (b < VPN_W * int'(level));
    end
  end

  assign vpn_ext = PPN_W'(vaddr[VA_W-1:OFF_W]);
  assign phys    = {leaf_ppn | (vpn_ext & sp_mask), vaddr[OFF_W-1:0]};

endmodule

// File: rtl/ptw_leaf_check.sv
module ptw_leaf_check
  import ptw_pkg::*;
#(
  parameter int PPN_W = 22,
  localparam int PTE_W = PTE_PPN_LSB + PPN_W
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [PPN_W-1:0] sp_mask,
  input  logic [1:0]       acc,
  input  logic [1:0]       mode,
  input  logic             sum,
  input  logic             mxr,
  output logic             is_ptr,
  output logic             leaf_ok,
  output logic             p_r,
  output logic             p_w,
  output logic             p_x,
  output logic [PTE_W-1:0] upd_pte
);

  logic v, r, w, x, u, d;
  logic [PPN_W-1:0] ppn;
  logic bad_rsvd, bad_user, bad_sup, bad_align, bad_acc;

  assign v   = pte[B_V];
  assign r   = pte[B_R];
  assign w   = pte[B_W];
  assign x   = pte[B_X];
  assign u   = pte[B_U];
  assign d   = pte[B_D];
  assign ppn = pte[PTE_PPN_LSB +: PPN_W];

  assign is_ptr = v & ~r & ~w & ~x;

  always_comb begin
    bad_rsvd  = ~r & w;
    bad_user  = u & (mode != MODE_U) & (~sum | (acc == ACC_FETCH));
    bad_sup   = ~u & (mode != MODE_S);
    bad_align = |(ppn & sp_mask);
    unique case (acc)
      ACC_LOAD:  bad_acc = ~(r | (x & mxr));
      ACC_STORE: bad_acc = ~w;
      ACC_FETCH: bad_acc = ~x;
      default:   bad_acc = 1'b1;
    endcase
  end

  assign leaf_ok = v & ~is_ptr & ~bad_rsvd & ~bad_user & ~bad_sup & ~bad_align & ~bad_acc;

  assign p_r = r | (x & mxr);
  assign p_w = w & ((acc == ACC_STORE) | d);
  assign p_x = x;

  always_comb begin
    upd_pte      = pte;
    upd_pte[B_A] = 1'b1;
    if (acc == ACC_STORE) upd_pte[B_D] = 1'b1;
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int PPN_W = 22,
  parameter int VPN_W = 10,
  parameter int LEVELS = 2,
  parameter int OFF_W = 12,
  localparam int VA_W = OFF_W + VPN_W * LEVELS,
  localparam int PA_W = OFF_W + PPN_W,
  localparam int PTE_W = PTE_PPN_LSB + PPN_W,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_acc,
  input  logic [1:0]       req_mode,
  input  logic             req_sum,
  input  logic             req_mxr,
  input  logic [PPN_W-1:0] req_root,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [PTE_W-1:0] mem_rdata,
  output logic             done,
  output logic             fault,
  output logic [PA_W-1:0]  pa,
  output logic             perm_r,
  output logic             perm_w,
  output logic             perm_x
);

  walk_st_e         state;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic [1:0]       mode_q;
  logic             sum_q;
  logic             mxr_q;
  logic [PPN_W-1:0] base_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PTE_W-1:0] pte_q;
  logic [PA_W-1:0]  res_pa;
  logic [2:0]       res_perm;

  logic [PA_W-1:0]  gen_addr;
  logic [PA_W-1:0]  gen_phys;
  logic [PPN_W-1:0] gen_mask;
  logic             is_ptr, leaf_ok, c_r, c_w, c_x;
  logic [PTE_W-1:0] upd_pte;
  logic [PPN_W-1:0] pte_ppn;

  assign pte_ppn = pte_q[PTE_PPN_LSB +: PPN_W];

  ptw_addr_gen #(
    .PPN_W (PPN_W),
    .VPN_W (VPN_W),
    .LEVELS(LEVELS),
    .OFF_W (OFF_W)
  ) u_addr (
    .vaddr   (va_q),
    .base_ppn(base_q),
    .level   (lvl_q),
    .leaf_ppn(pte_ppn),
    .pte_addr(gen_addr),
    .phys    (gen_phys),
    .sp_mask (gen_mask)
  );

  ptw_leaf_check #(
    .PPN_W(PPN_W)
  ) u_check (
    .pte    (pte_q),
    .sp_mask(gen_mask),
    .acc    (acc_q),
    .mode   (mode_q),
    .sum    (sum_q),
    .mxr    (mxr_q),
    .is_ptr (is_ptr),
    .leaf_ok(leaf_ok),
    .p_r    (c_r),
    .p_w    (c_w),
    .p_x    (c_x),
    .upd_pte(upd_pte)
  );

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      va_q      <= '0;
      acc_q     <= '0;
      mode_q    <= '0;
      sum_q     <= 1'b0;
      mxr_q     <= 1'b0;
      base_q    <= '0;
      lvl_q     <= '0;
      pte_q     <= '0;
      res_pa    <= '0;
      res_perm  <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      fault     <= 1'b0;
      pa        <= '0;
      perm_r    <= 1'b0;
      perm_w    <= 1'b0;
      perm_x    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q   <= req_vaddr;
            acc_q  <= req_acc;
            mode_q <= req_mode;
            sum_q  <= req_sum;
            mxr_q  <= req_mxr;
            base_q <= req_root;
            lvl_q  <= LVL_W'(LEVELS - 1);
            state  <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= gen_addr;
          state    <= ST_READ;
        end
        ST_READ: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            pte_q   <= mem_rdata;
            state   <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (is_ptr && (lvl_q != '0)) begin
            base_q <= pte_ppn;
            lvl_q  <= lvl_q - 1'b1;
            state  <= ST_ISSUE;
          end else if (!leaf_ok) begin
            done   <= 1'b1;
            fault  <= 1'b1;
            pa     <= '0;
            perm_r <= 1'b0;
            perm_w <= 1'b0;
            perm_x <= 1'b0;
            state  <= ST_IDLE;
          end else if (upd_pte != pte_q) begin
            res_pa    <= gen_phys;
            res_perm  <= {c_r, c_w, c_x};
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_wdata <= upd_pte;
            state     <= ST_WRITE;
          end else begin
            done   <= 1'b1;
            fault  <= 1'b0;
            pa     <= gen_phys;
            perm_r <= c_r;
            perm_w <= c_w;
            perm_x <= c_x;
            state  <= ST_IDLE;
          end
        end
        ST_WRITE: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            done    <= 1'b1;
            fault   <= 1'b0;
            pa      <= res_pa;
            perm_r  <= res_perm[2];
            perm_w  <= res_perm[1];
            perm_x  <= res_perm[0];
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_wb_changes_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_wdata[B_A] && (mem_wdata != pte_q)));

  p_store_dirty_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && (acc_q == ACC_STORE)) |-> mem_wdata[B_D]);

  p_fault_clean_r13: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> ((pa == '0) && !perm_r && !perm_w && !perm_x));

  p_write_perm_r12: assert property (@(posedge clk) disable iff (rst)
    (done && !fault && perm_w) |-> pte_q[B_W]);

endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [1:0]  req_acc;
  logic [1:0]  req_mode;
  logic        req_sum;
  logic        req_mxr;
  logic [21:0] req_root;
  logic        busy;
  logic        mem_req;
  logic        mem_we;
  logic [33:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic        done;
  logic        fault;
  logic [33:0] pa;
  logic        perm_r;
  logic        perm_w;
  logic        perm_x;

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] mem [0:2047];
  logic [33:0] rd_log [0:3];
  int          rd_n;
  int          wr_n;

  typedef struct {
    bit          f;
    string       why;
    logic [33:0] pa;
    bit          r, w, x;
    bit          wr;
    int          widx;
    logic [31:0] wval;
    logic [31:0] old;
    int          nreads;
    logic [33:0] addr0;
  } exp_t;

  always #10 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc),
    .req_mode(req_mode), .req_sum(req_sum), .req_mxr(req_mxr), .req_root(req_root),
    .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .pa(pa),
    .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
  );

  // single-cycle-latency memory responder
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[12:2]] = mem_wdata;
        wr_n = wr_n + 1;
      end else begin
        mem_rdata <= mem[mem_addr[12:2]];
        if (rd_n < 4) rd_log[rd_n] = mem_addr;
        rd_n = rd_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  // reference walk, computed from the requirements
  function automatic exp_t model(input logic [31:0] va, input logic [1:0] acc,
                                 input logic [1:0] mode, input bit sum, input bit mxr);
    exp_t e;
    int idx;
    int lvl;
    logic [31:0] pte;
    logic [21:0] ppn;
    bit v, r, w, x, u, d;
    idx     = int'(va[31:22]);
    e.addr0 = {22'd0, va[31:22], 2'b00};
    e.nreads = 1;
    lvl = 1;
    pte = mem[idx];
    if (pte[0] && pte[3:1] == 3'b000) begin
      lvl = 0;
      idx = (int'(pte[31:10]) * 1024 + int'(va[21:12])) & 2047;
      e.nreads = 2;
      pte = mem[idx];
    end
    e.widx = idx;
    e.old  = pte;
    v = pte[0]; r = pte[1]; w = pte[2]; x = pte[3]; u = pte[4]; d = pte[7];
    ppn = pte[31:10];
    e.f = 1'b1;
    if (!v) e.why = "R3";
    else if (!r && !w && !x) e.why = "R4";
    else if (!r && w) e.why = "R5";
    else if (u && mode != 2'd0 && (!sum || acc == 2'd2)) e.why = "R6";
    else if (!u && mode != 2'd1) e.why = "R7";
    else if (lvl == 1 && ppn[9:0] != 10'd0) e.why = "R8";
    else if ((acc == 2'd0 && !(r || (x && mxr))) || (acc == 2'd1 && !w) || (acc == 2'd2 && !x))
      e.why = "R9";
    else begin
      e.f = 1'b0;
      e.why = "R11";
    end
    if (e.f) begin
      e.pa = '0; e.r = 0; e.w = 0; e.x = 0; e.wr = 0; e.wval = pte;
    end else begin
      e.pa = (lvl == 1) ? {ppn[21:10], va[21:12], va[11:0]} : {ppn, va[11:0]};
      e.r = r || (x && mxr);
      e.w = w && (acc == 2'd1 || d);
      e.x = x;
      e.wval = pte | 32'h40 | ((acc == 2'd1) ? 32'h80 : 32'h0);
      e.wr = (e.wval != pte);
    end
    return e;
  endfunction

  task automatic run(input logic [31:0] va, input logic [1:0] acc, input logic [1:0] mode,
                     input bit sum, input bit mxr);
    exp_t e;
    int n;
    e = model(va, acc, mode, sum, mxr);
    rd_n = 0;
    wr_n = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    req_acc   = acc;
    req_mode  = mode;
    req_sum   = sum;
    req_mxr   = mxr;
    req_root  = 22'd0;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      chk(1'b0, "R1", "walk timeout", 64'(n), 64'd0);
      return;
    end
    chk(fault == e.f, e.why, "fault", 64'(fault), 64'(e.f));
    if (e.f) begin
      chk(pa == 34'd0 && {perm_r, perm_w, perm_x} == 3'b000, "R13", "outputs on fault",
          64'({pa, perm_r, perm_w, perm_x}), 64'd0);
    end else begin
      chk(pa == e.pa, "R11", "pa", 64'(pa), 64'(e.pa));
      chk({perm_r, perm_w, perm_x} == {e.r, e.w, e.x}, "R12", "perms",
          64'({perm_r, perm_w, perm_x}), 64'({e.r, e.w, e.x}));
    end
    chk(wr_n == (e.wr ? 1 : 0), "R10", "write count", 64'(wr_n), 64'(e.wr ? 1 : 0));
    chk(mem[e.widx] == e.wval, "R10", "entry after walk", 64'(mem[e.widx]), 64'(e.wval));
    chk(rd_n == e.nreads, "R2", "read count", 64'(rd_n), 64'(e.nreads));
    chk(rd_log[0] == e.addr0, "R2", "first read addr", 64'(rd_log[0]), 64'(e.addr0));
    if (e.nreads == 2 && rd_n >= 2)
      chk(rd_log[1] == {22'd1, va[21:12], 2'b00}, "R2", "second read addr",
          64'(rd_log[1]), 64'({22'd1, va[21:12], 2'b00}));
  endtask

  // place a 4 KiB leaf behind a pointer to table page 1
  task automatic put_small(input logic [31:0] va, input logic [31:0] leaf);
    mem[int'(va[31:22])] = 32'h0000_0401;
    mem[1024 + int'(va[21:12])] = leaf;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] va;
    logic [31:0] flg;
    logic [21:0] ppn;
    int shape;
    int m;
    void'($urandom(32'd4242));
    for (int i = 0; i < 2048; i++) mem[i] = 32'd0;
    rd_n = 0;
    wr_n = 0;
    rst = 1'b1;
    req_valid = 1'b0;
    req_vaddr = '0;
    req_acc = '0;
    req_mode = '0;
    req_sum = 1'b0;
    req_mxr = 1'b0;
    req_root = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !fault && !mem_req, "R1", "reset state",
        64'({busy, done, fault, mem_req}), 64'd0);

    // R10 store to a clean user page from user mode sets A and D
    va = 32'h0040_3123;
    put_small(va, {22'h00ABC, 10'h017});
    run(va, 2'd1, 2'd0, 0, 0);
    // R10 load with A already set: no write
    va = 32'h0080_5456;
    put_small(va, {22'h00123, 10'h053});
    run(va, 2'd0, 2'd0, 0, 0);
    // R9 R12 execute-only page loaded with and without MXR
    va = 32'h00C0_7789;
    put_small(va, {22'h00777, 10'h049});
    run(va, 2'd0, 2'd1, 0, 1);
    run(va, 2'd0, 2'd1, 0, 0);
    // R6 user page from supervisor: load allowed with SUM, fetch not
    va = 32'h0100_9000;
    put_small(va, {22'h00055, 10'h05B});
    run(va, 2'd0, 2'd1, 1, 0);
    run(va, 2'd2, 2'd1, 1, 0);
    run(va, 2'd0, 2'd1, 0, 0);
    // R7 supervisor page from user and machine mode
    va = 32'h0140_1000;
    put_small(va, {22'h00066, 10'h04B});
    run(va, 2'd0, 2'd0, 0, 0);
    run(va, 2'd0, 2'd3, 0, 0);
    // R5 reserved encodings
    va = 32'h0180_2000;
    put_small(va, {22'h00011, 10'h045});
    run(va, 2'd1, 2'd1, 0, 0);
    put_small(va, {22'h00011, 10'h04D});
    run(va, 2'd2, 2'd1, 0, 0);
    // R8 misaligned and aligned 4 MiB pages
    va = 32'h01C0_4ABC;
    mem[int'(va[31:22])] = {22'h3F001, 10'h0CF};
    run(va, 2'd0, 2'd1, 0, 0);
    mem[int'(va[31:22])] = {22'h3F000, 10'h0CF};
    run(va, 2'd1, 2'd1, 0, 0);
    // R4 pointer in the last table
    va = 32'h0200_5000;
    put_small(va, {22'h00001, 10'h001});
    run(va, 2'd0, 2'd1, 0, 0);
    // R3 invalid entries at either level
    va = 32'h0240_6000;
    mem[int'(va[31:22])] = 32'h0000_04CE;
    run(va, 2'd0, 2'd1, 0, 0);
    put_small(va, {22'h00022, 10'h0CE});
    run(va, 2'd0, 2'd1, 0, 0);
    // R12 write permission from dirty on a load
    va = 32'h0280_7000;
    put_small(va, {22'h00033, 10'h0C7});
    run(va, 2'd0, 2'd1, 0, 0);

    for (int t = 0; t < 400; t++) begin
      va    = $urandom;
      shape = int'($urandom % 4);
      flg   = $urandom & 32'h3FF;
      if (($urandom % 10) != 0) flg[0] = 1'b1;
      if (flg[0] && flg[3:1] == 3'b000) flg[1] = 1'b1;
      ppn = 22'($urandom);
      if (shape == 0) begin
        if ($urandom % 2 == 0) ppn[9:0] = 10'd0;
        mem[int'(va[31:22])] = {ppn, flg[9:0]};
      end else if (shape == 3) begin
        put_small(va, {ppn, 10'h001});
      end else begin
        put_small(va, {ppn, flg[9:0]});
      end
      m = int'($urandom % 3);
      run(va, 2'($urandom % 3), (m == 2) ? 2'd3 : 2'(m), 1'($urandom), 1'($urandom));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule